// File: doc/BRIEF.md
# Switch Management Tag Inserter

This block sits on the egress path from a host processor to an Ethernet switch. Frames arrive one byte per beat on an AXI4-Stream style input together with the number of the switch port they are meant for. The block forwards the two MAC addresses (the first twelve bytes) as they are. It then splices in a two-byte routing header and forwards the rest of the frame, starting at the EtherType, unchanged. The switch reads this header to steer the frame to a single front port.

The header is `0x80` followed by `0x80 | (1 << port)`. That is: version code 2 in the top two bits, zero priority and control fields, a from-CPU flag in bit 7, and a one-hot port mask in bits 6:0. Every output beat is registered, and the output side honours full backpressure. While the two header beats are being emitted, the input is held off. Two saturating counters report the number of frames accepted and the number of untagged bytes accepted.

Top module: `mgmt_tag_inserter`

## Requirements
- R1: During and right after synchronous reset, `m_tvalid` is 0, `s_tready` is 1, and both counters read 0.
- R2: For a frame longer than 12 bytes, output bytes 0..11 equal input bytes 0..11. Output bytes 12 and 13 are the header. Output byte k+2 equals input byte k for every k of 12 or more.
- R3: The first header byte (output byte 12) is 0x80: bits 15:14 hold 2, and bits 13:8 (priority and control) are 0.
- R4: The second header byte (output byte 13) has bit 7 set. Bits 6:0 have only bit `p` set, where `p` is the `s_dest_port` value sampled with the first byte of the frame.
- R5: A port value of 7 gives a second header byte of 0x80 (empty mask). For such a frame `m_terr` is 1 on every output beat; for any other frame it is 0.
- R6: `m_tlast` is high only on the output beat that carries the last input byte. A tagged frame therefore leaves exactly 2 bytes longer than it entered.
- R7: `s_tready` is 0 for the two cycles the header beats take. While `m_tvalid` is 1 and `m_tready` is 0, the output beat is held stable. No byte is lost or duplicated under any backpressure pattern.
- R8: A frame of 12 bytes or fewer passes through unchanged, with no header.
- R9: `frame_count` increments on each accepted input beat with `s_tlast` set, and holds at its all-ones value.
- R10: `byte_count` increments on each accepted input byte (header bytes excluded), and holds at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 8 | Input frame byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted when high together with valid |
| s_tlast | input | 1 | Last byte of input frame |
| s_dest_port | input | PORT_W (3) | Destination switch port, sampled with the first byte |
| m_tdata | output | 8 | Output byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Last byte of output frame |
| m_terr | output | 1 | Frame carries an out-of-range destination port |
| frame_count | output | FRAME_CNT_W (16) | Saturating count of accepted frames |
| byte_count | output | BYTE_CNT_W (32) | Saturating count of accepted input bytes |

## Verification
The bench builds the block with a 4-bit frame counter and an 8-bit byte counter, keeping the other parameters at their defaults. These narrow widths let a run of eighteen short frames push both counters past their ceilings, so the hold at all-ones is exercised rather than assumed. With the default 12-byte address span and 7 ports, the bench covers every valid port, the out-of-range value 7, frames of 5, 12 and 13 bytes around the splice point, and a full-rate run in which the two-cycle input stall can be timed exactly.

// File: rtl/mgmt_tag_pkg.sv
package mgmt_tag_pkg;
  localparam int MASK_W = 7;
  localparam logic [1:0] HDR_VERSION = 2'b10;

  typedef enum logic [1:0] {
    ST_ADDR   = 2'd0,
    ST_HDR_HI = 2'd1,
    ST_HDR_LO = 2'd2,
    ST_BODY   = 2'd3
  } splice_state_t;
endpackage

// File: rtl/mgmt_tag_hdr_gen.sv
module mgmt_tag_hdr_gen
  import mgmt_tag_pkg::*;
#(
  parameter int PORT_W    = 3,
  parameter int NUM_PORTS = 7
) (
  input  logic [PORT_W-1:0] port,
  output logic [15:0]       hdr,
  output logic              bad_port
);
  logic [MASK_W-1:0] mask;

  for (genvar k = 0; k < MASK_W; k++) begin : g_mask
    if (k < NUM_PORTS) begin : g_live
      assign mask[k] = (port == PORT_W'(k));
    end else begin : g_dead
      assign mask[k] = 1'b0;
    end
  end

  assign bad_port = (int'(port) >= NUM_PORTS);
  // version | priority 0 | control 0 | from-cpu | one-hot mask
  assign hdr = {HDR_VERSION, 3'b000, 3'b000, 1'b1, mask};
endmodule

// File: rtl/mgmt_tag_sat_cnt.sv
module mgmt_tag_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && (count != {W{1'b1}})) begin
      count <= count + W'(1);
    end
  end
endmodule

// File: rtl/mgmt_tag_splice.sv
module mgmt_tag_splice
  import mgmt_tag_pkg::*;
#(
  parameter int HDR_OFFSET = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  s_tdata,
  input  logic        s_tvalid,
  output logic        s_tready,
  input  logic        s_tlast,
  input  logic [15:0] hdr_in,
  input  logic        err_in,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast,
  output logic        m_terr,
  output logic        acc_beat,
  output logic        acc_last
);
  localparam int CNT_W = $clog2(HDR_OFFSET + 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(HDR_OFFSET - 1);

  splice_state_t    state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      hdr_q;
  logic             err_q;
  logic [7:0]       dat_q;
  logic             vld_q, lst_q, erf_q;

  logic load, data_phase, accept, first_byte, beat_err;

  assign load       = !vld_q || m_tready;
  assign data_phase = (state_q == ST_ADDR) || (state_q == ST_BODY);
  assign s_tready   = load && data_phase;
  assign accept     = s_tvalid && s_tready;
  assign first_byte = (state_q == ST_ADDR) && (cnt_q == '0);
  assign beat_err   = first_byte ? err_in : err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      hdr_q   <= '0;
      err_q   <= 1'b0;
      dat_q   <= '0;
      vld_q   <= 1'b0;
      lst_q   <= 1'b0;
      erf_q   <= 1'b0;
    end else if (load) begin
      case (state_q)
        ST_ADDR: begin
          vld_q <= accept;
          if (accept) begin
            dat_q <= s_tdata;
            lst_q <= s_tlast;
            erf_q <= beat_err;
            if (first_byte) begin
              hdr_q <= hdr_in;
              err_q <= err_in;
            end
            if (s_tlast) begin
              cnt_q <= '0;
            end else if (cnt_q == LAST_ADDR) begin
              cnt_q   <= '0;
              state_q <= ST_HDR_HI;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_HDR_HI: begin
          vld_q   <= 1'b1;
          dat_q   <= hdr_q[15:8];
          lst_q   <= 1'b0;
          erf_q   <= err_q;
          state_q <= ST_HDR_LO;
        end
        ST_HDR_LO: begin
          vld_q   <= 1'b1;
          dat_q   <= hdr_q[7:0];
          lst_q   <= 1'b0;
          erf_q   <= err_q;
          state_q <= ST_BODY;
        end
        default: begin
          vld_q <= accept;
          if (accept) begin
            dat_q <= s_tdata;
            lst_q <= s_tlast;
            erf_q <= err_q;
            if (s_tlast) state_q <= ST_ADDR;
          end
        end
      endcase
    end
  end

  assign m_tdata  = dat_q;
  assign m_tvalid = vld_q;
  assign m_tlast  = lst_q;
  assign m_terr   = erf_q;
  assign acc_beat = accept;
  assign acc_last = accept && s_tlast;
endmodule

// File: rtl/mgmt_tag_inserter.sv
module mgmt_tag_inserter #(
  parameter int PORT_W      = 3,
  parameter int NUM_PORTS   = 7,
  parameter int HDR_OFFSET  = 12,
  parameter int FRAME_CNT_W = 16,
  parameter int BYTE_CNT_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [7:0]             s_tdata,
  input  logic                   s_tvalid,
  output logic                   s_tready,
  input  logic                   s_tlast,
  input  logic [PORT_W-1:0]      s_dest_port,
  output logic [7:0]             m_tdata,
  output logic                   m_tvalid,
  input  logic                   m_tready,
  output logic                   m_tlast,
  output logic                   m_terr,
  output logic [FRAME_CNT_W-1:0] frame_count,
  output logic [BYTE_CNT_W-1:0]  byte_count
);
  logic [15:0] hdr;
  logic        bad_port;
  logic        acc_beat, acc_last;

  mgmt_tag_hdr_gen #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_hdr (
    .port     (s_dest_port),
    .hdr      (hdr),
    .bad_port (bad_port)
  );

  mgmt_tag_splice #(.HDR_OFFSET(HDR_OFFSET)) u_splice (
    .clk      (clk),
    .rst      (rst),
    .s_tdata  (s_tdata),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .s_tlast  (s_tlast),
    .hdr_in   (hdr),
    .err_in   (bad_port),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast),
    .m_terr   (m_terr),
    .acc_beat (acc_beat),
    .acc_last (acc_last)
  );

  mgmt_tag_sat_cnt #(.W(FRAME_CNT_W)) u_frames (
    .clk (clk), .rst (rst), .inc (acc_last), .count (frame_count)
  );

  mgmt_tag_sat_cnt #(.W(BYTE_CNT_W)) u_bytes (
    .clk (clk), .rst (rst), .inc (acc_beat), .count (byte_count)
  );
endmodule

// File: rtl/mgmt_tag_checker.sv
module mgmt_tag_checker #(
  parameter int FRAME_CNT_W = 16,
  parameter int BYTE_CNT_W  = 32,
  parameter int HDR_OFFSET  = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   s_tready,
  input logic [7:0]             m_tdata,
  input logic                   m_tvalid,
  input logic                   m_tready,
  input logic                   m_tlast,
  input logic                   m_terr,
  input logic [FRAME_CNT_W-1:0] frame_count,
  input logic [BYTE_CNT_W-1:0]  byte_count
);
  logic [7:0] idx;
  logic       at_hi, at_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (m_tvalid && m_tready) begin
      if (m_tlast) idx <= '0;
      else if (idx != 8'hff) idx <= idx + 8'd1;
    end
  end

  assign at_hi = m_tvalid && (int'(idx) == HDR_OFFSET);
  assign at_lo = m_tvalid && (int'(idx) == HDR_OFFSET + 1);

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R7

  AST_HDR_HIGH: assert property (@(posedge clk) disable iff (rst)
    at_hi |-> (m_tdata == 8'h80 && !m_tlast)); // R3

  AST_HDR_LOW: assert property (@(posedge clk) disable iff (rst)
    at_lo |-> (m_tdata[7] && !m_tlast &&
               ($countones(m_tdata[6:0]) == (m_terr ? 0 : 1)))); // R4

  AST_FRAME_SAT: assert property (@(posedge clk) disable iff (rst)
    (frame_count >= $past(frame_count)) &&
    (frame_count - $past(frame_count) <= FRAME_CNT_W'(1))); // R9

  AST_BYTE_SAT: assert property (@(posedge clk) disable iff (rst)
    (byte_count >= $past(byte_count)) &&
    (byte_count - $past(byte_count) <= BYTE_CNT_W'(1))); // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!m_tvalid && frame_count == '0 && byte_count == '0)); // R1
endmodule

bind mgmt_tag_inserter mgmt_tag_checker #(
  .FRAME_CNT_W (FRAME_CNT_W),
  .BYTE_CNT_W  (BYTE_CNT_W),
  .HDR_OFFSET  (HDR_OFFSET)
) u_chk (.*);

// File: tb/mgmt_tag_inserter_bench.sv
module mgmt_tag_inserter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FCW = 4;
  localparam int BCW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] s_tdata = '0;
  logic s_tvalid = 1'b0;
  logic s_tlast = 1'b0;
  logic [2:0] s_dest_port = '0;
  logic m_tready = 1'b1;
  logic s_tready, m_tvalid, m_tlast, m_terr;
  logic [7:0] m_tdata;
  logic [FCW-1:0] frame_count;
  logic [BCW-1:0] byte_count;

  int checks = 0;
  int failures = 0;
  bit bp_mode = 1'b0;
  int stall_seen;

  typedef struct {
    logic [7:0] d;
    logic       l;
    logic       e;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mgmt_tag_inserter #(.FRAME_CNT_W(FCW), .BYTE_CNT_W(BCW)) u_mgmt_tag_inserter (
    .clk (clk), .rst (rst),
    .s_tdata (s_tdata), .s_tvalid (s_tvalid), .s_tready (s_tready),
    .s_tlast (s_tlast), .s_dest_port (s_dest_port),
    .m_tdata (m_tdata), .m_tvalid (m_tvalid), .m_tready (m_tready),
    .m_tlast (m_tlast), .m_terr (m_terr),
    .frame_count (frame_count), .byte_count (byte_count)
  );

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(logic [7:0] d, logic l, logic e, string tag);
    exp_t it;
    it.d = d; it.l = l; it.e = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // downstream ready: random in backpressure mode
  always @(posedge clk) begin
    #1;
    m_tready = bp_mode ? (($urandom % 4) != 0) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && m_tvalid && m_tready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected extra beat", int'(m_tdata), 0);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        chk(m_tdata == it.d, it.tag, "data", int'(m_tdata), int'(it.d));
        chk(m_tlast == it.l, "R6", "tlast", int'(m_tlast), int'(it.l));
        chk(m_terr == it.e, "R5", "terr", int'(m_terr), int'(it.e));
      end
    end
  end

  task automatic send_frame(int len, logic [2:0] port, int id);
    logic e;
    logic [7:0] lo;
    e  = (port == 3'd7);
    lo = e ? 8'h80 : (8'h80 | (8'h01 << port));
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'((id * 17 + i * 5) & 255);
      if (i == 12) begin
        push(8'h80, 1'b0, e, "R3");
        push(lo, 1'b0, e, "R4");
      end
      push(b, (i == len - 1), e, (len > 12) ? "R2" : "R8");
    end
    for (int i = 0; i < len; i++) begin
      bit acc;
      if (bp_mode && (($urandom % 5) == 0)) begin
        @(posedge clk); #1;
        s_tvalid = 1'b0;
      end
      @(posedge clk); #1;
      s_tvalid    = 1'b1;
      s_tdata     = 8'((id * 17 + i * 5) & 255);
      s_tlast     = (i == len - 1);
      s_dest_port = port;
      if (i == 12) stall_seen = 0;
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        acc = s_tready;
        if (!acc && i == 12) stall_seen++;
        if (!acc) begin
          @(posedge clk); #1;
        end
      end
    end
    @(posedge clk); #1;
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(posedge clk);
      n++;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R6", "leftover expected beats", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(m_tvalid == 1'b0, "R1", "m_tvalid after reset", int'(m_tvalid), 0);
    chk(s_tready == 1'b1, "R1", "s_tready after reset", int'(s_tready), 1);
    chk(frame_count == 0, "R1", "frame_count after reset", int'(frame_count), 0);
    chk(byte_count == 0, "R1", "byte_count after reset", int'(byte_count), 0);

    // full-rate phase
    send_frame(20, 3'd0, 1);
    chk(stall_seen == 2, "R7", "input stall cycles during header", stall_seen, 2);
    send_frame(64, 3'd6, 2);
    chk(stall_seen == 2, "R7", "input stall cycles during header", stall_seen, 2);
    send_frame(16, 3'd7, 3);   // R5 out-of-range port
    send_frame(13, 3'd3, 4);
    send_frame(12, 3'd2, 5);   // R8 no header
    send_frame(5,  3'd5, 6);   // R8 short
    drain();
    chk(frame_count == 6, "R9", "frame_count", int'(frame_count), 6);
    chk(byte_count == 130, "R10", "byte_count", int'(byte_count), 130);

    // backpressure phase, drives counters into saturation
    bp_mode = 1'b1;
    for (int k = 0; k < 12; k++) begin
      send_frame(13 + (k * 7) % 40, 3'(k % 8), 10 + k);
    end
    drain();
    bp_mode = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(frame_count == 15, "R9", "frame_count saturated", int'(frame_count), 15);
    chk(byte_count == 255, "R10", "byte_count saturated", int'(byte_count), 255);
    chk(m_tvalid == 1'b0, "R6", "idle after drain", int'(m_tvalid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule